// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block is an asynchronous serial receiver for a shared line on which many nodes listen. Each frame has a low start bit, eight data bits sent least significant bit first, one address-marker bit and one high stop bit. A marker of 1 means the byte is a node address. A marker of 0 means the byte is payload. The line is oversampled sixteen times per bit. The oversampling tick comes from a plain clock divider.

Software writes a configuration strobe that sets the receive enable and the address-hunt flag. While the hunt flag is set, payload frames are discarded silently. The next address frame is stored, and hardware clears the hunt flag itself. Software then compares the stored byte against its own address. If the address does not match, software sets the hunt flag again. When it matches, all later frames are accepted.

Three sticky flags report status: byte ready, overrun and framing error. Software clears each one with a clear strobe. While an overrun or framing error is pending, the receiver takes no new frame. The synchronised line level is always visible, so software can detect a break after a framing error.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, rx_en_o, hunt_o, full_o, ovr_o and frm_o are 0, and data_o is 0x00.
- R2: With reception enabled, the sequence start bit 0, eight data bits (LSB first), marker bit and stop bit 1 loads the byte into data_o and sets full_o to 1.
- R3: While hunt_o is 1, a frame whose marker bit is 0 changes neither data_o, full_o, ovr_o nor frm_o. This holds even when its stop bit is 0.
- R4: While hunt_o is 1, a valid frame whose marker bit is 1 is loaded and clears hunt_o to 0.
- R5: While hunt_o is 0, frames are loaded whatever their marker bit.
- R6: A valid frame that completes while full_o is 1 sets ovr_o to 1 and leaves data_o unchanged.
- R7: While ovr_o or frm_o is 1, no frame is accepted. After both flags are cleared through clr_we, reception resumes.
- R8: A non-hunted frame whose stop bit samples as 0 sets frm_o to 1 and leaves data_o and full_o unchanged.
- R9: line_o follows rxd_i after two clock cycles of synchronisation.
- R10: Writing rx_en 0 through cfg_we abandons a frame in progress. No flag or data changes for it.
- R11: A low pulse on rxd_i that is shorter than half a bit period does not start a frame.
- R12: clr_we with clr_full at 1 clears full_o. A cfg_we write sets rx_en_o and hunt_o to the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rx_en | input | 1 | Receive enable value written by cfg_we |
| cfg_hunt | input | 1 | Address-hunt value written by cfg_we |
| clr_we | input | 1 | Flag clear strobe |
| clr_full | input | 1 | Clear byte-ready flag with clr_we |
| clr_ovr | input | 1 | Clear overrun flag with clr_we |
| clr_frm | input | 1 | Clear framing flag with clr_we |
| rx_en_o | output | 1 | Current receive enable |
| hunt_o | output | 1 | Address-hunt flag |
| data_o | output | 8 | Last accepted byte |
| full_o | output | 1 | Byte ready |
| ovr_o | output | 1 | Overrun |
| frm_o | output | 1 | Framing error |
| line_o | output | 1 | Synchronised line level |

## Verification
The properties assume that software never writes a configuration or clear strobe in the same cycle in which a frame completes. They also assume that the line changes no faster than the oversampling tick can follow. The bench drives whole bit periods of sixteen ticks each. The only deliberately short pulse is the glitch for R11. It issues every register write while the line is idle, or while a frame is still in its middle, and never at a stop-bit sample. Each result is checked only after the stop bit and one idle bit have passed.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
    localparam int DATA_W = 8;
    localparam int OVS    = 16;
    localparam int CNT_W  = $clog2(OVS);
    localparam int SH_W   = DATA_W + 1;
    localparam int IDX_W  = $clog2(SH_W + 1);

    typedef enum logic [1:0] {FS_IDLE, FS_START, FS_BITS} fstate_e;

    typedef struct packed {
        fstate_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [IDX_W-1:0]    idx;
        logic [SH_W-1:0]     sh;
        logic                prev;
        logic                done;
        logic                stop;
    } fr_state_t;

    typedef struct packed {
        logic              rx_en;
        logic              hunt;
        logic [DATA_W-1:0] data;
        logic              full;
        logic              ovr;
        logic              frm;
    } reg_state_t;
endpackage

// File: rtl/mpuart_baud.sv
module mpuart_baud #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == CW'(DIV - 1)) cnt_d = '0;
        else                       cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/mpuart_sync.sv
module mpuart_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_d, sr_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sr_d = d_i;
        end else begin : g_many
            always_comb sr_d = {sr_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mpuart_frame.sv
module mpuart_frame
    import mpuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              rx_i,
    output logic              done_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              mpb_o,
    output logic              stop_o
);
    localparam int HALF = OVS / 2;
    localparam int LAST = SH_W;

    fr_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!en_i) begin
            s_d.st   = FS_IDLE;
            s_d.prev = rx_i;
        end else if (tick_i) begin
            s_d.prev = rx_i;
            case (s_q.st)
                FS_IDLE: begin
                    if (s_q.prev && !rx_i) begin
                        s_d.st  = FS_START;
                        s_d.cnt = '0;
                    end
                end
                FS_START: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == CNT_W'(HALF - 1)) begin
                        if (!rx_i) begin
                            s_d.st  = FS_BITS;
                            s_d.cnt = '0;
                            s_d.idx = '0;
                        end else begin
                            s_d.st = FS_IDLE;
                        end
                    end
                end
                FS_BITS: begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == CNT_W'(OVS - 1)) begin
                        s_d.cnt = '0;
                        if (s_q.idx == IDX_W'(LAST)) begin
                            s_d.done = 1'b1;
                            s_d.stop = rx_i;
                            s_d.st   = FS_IDLE;
                        end else begin
                            s_d.sh  = {rx_i, s_q.sh[SH_W-1:1]};
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end
                end
                default: s_d.st = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= FS_IDLE;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = s_q.done;
    assign byte_o = s_q.sh[DATA_W-1:0];
    assign mpb_o  = s_q.sh[DATA_W];
    assign stop_o = s_q.stop;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_pkg::*;
#(
    parameter int CLK_DIV     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              cfg_we,
    input  logic              cfg_rx_en,
    input  logic              cfg_hunt,
    input  logic              clr_we,
    input  logic              clr_full,
    input  logic              clr_ovr,
    input  logic              clr_frm,
    output logic              rx_en_o,
    output logic              hunt_o,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              frm_o,
    output logic              line_o
);
    logic              tick;
    logic              rx_s;
    logic              fr_en;
    logic              fr_done;
    logic [DATA_W-1:0] fr_byte;
    logic              fr_mpb;
    logic              fr_stop;

    reg_state_t r_d, r_q;

    mpuart_baud #(.DIV(CLK_DIV)) u_baud (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    mpuart_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(rx_s)
    );

    assign fr_en = r_q.rx_en & ~r_q.ovr & ~r_q.frm;

    mpuart_frame u_frame (
        .clk(clk), .rst_n(rst_n), .en_i(fr_en), .tick_i(tick), .rx_i(rx_s),
        .done_o(fr_done), .byte_o(fr_byte), .mpb_o(fr_mpb), .stop_o(fr_stop)
    );

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            r_d.rx_en = cfg_rx_en;
            r_d.hunt  = cfg_hunt;
        end
        if (clr_we) begin
            if (clr_full) r_d.full = 1'b0;
            if (clr_ovr)  r_d.ovr  = 1'b0;
            if (clr_frm)  r_d.frm  = 1'b0;
        end
        if (fr_done) begin
            if (r_q.hunt && !fr_mpb) begin
                r_d.data = r_q.data;
            end else if (!fr_stop) begin
                r_d.frm = 1'b1;
            end else if (r_q.full) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.data = fr_byte;
                r_d.full = 1'b1;
                if (r_q.hunt) r_d.hunt = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_en_o = r_q.rx_en;
    assign hunt_o  = r_q.hunt;
    assign data_o  = r_q.data;
    assign full_o  = r_q.full;
    assign ovr_o   = r_q.ovr;
    assign frm_o   = r_q.frm;
    assign line_o  = rx_s;
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic       fr_done,
    input logic       fr_mpb,
    input logic       rx_en_o,
    input logic       hunt_o,
    input logic [7:0] data_o,
    input logic       full_o,
    input logic       ovr_o,
    input logic       frm_o
);
    p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hunt_o && fr_done && !fr_mpb) |=> ($stable(data_o) && !$rose(full_o) && !$rose(frm_o) && !$rose(ovr_o)));

    p_hunt_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hunt_o) && !$past(cfg_we)) |-> full_o);

    p_ovr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $stable(data_o));

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o || frm_o) |=> !$rose(full_o));

    p_frm_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frm_o) |-> ($stable(data_o) && !$rose(full_o)));

    p_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_o |=> (!$rose(full_o) && !$rose(frm_o) && !$rose(ovr_o)));
endmodule

bind mpuart_rx mpuart_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .fr_done(fr_done), .fr_mpb(fr_mpb),
    .rx_en_o(rx_en_o), .hunt_o(hunt_o), .data_o(data_o), .full_o(full_o),
    .ovr_o(ovr_o), .frm_o(frm_o)
);

// File: tb/mpuart_rx_tb.sv
`timescale 1ns/1ps
module mpuart_rx_tb;
    localparam int CLK_DIV = 2;
    localparam int BIT_CLK = 16 * CLK_DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd_i = 1'b1;
    logic cfg_we = 1'b0, cfg_rx_en = 1'b0, cfg_hunt = 1'b0;
    logic clr_we = 1'b0, clr_full = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0;
    logic rx_en_o, hunt_o, full_o, ovr_o, frm_o, line_o;
    logic [7:0] data_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mpuart_rx #(.CLK_DIV(CLK_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i),
        .cfg_we(cfg_we), .cfg_rx_en(cfg_rx_en), .cfg_hunt(cfg_hunt),
        .clr_we(clr_we), .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_frm(clr_frm),
        .rx_en_o(rx_en_o), .hunt_o(hunt_o), .data_o(data_o), .full_o(full_o),
        .ovr_o(ovr_o), .frm_o(frm_o), .line_o(line_o)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       mpb;
        logic       stop;
        logic       e_full;
        logic [7:0] e_data;
        logic       e_hunt;
        logic       e_frm;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{8'h99, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
        '{8'h11, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},
        '{8'h42, 1'b1, 1'b1, 1'b1, 8'h42, 1'b0, 1'b0},
        '{8'hA5, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0},
        '{8'h3C, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd_i = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic mpb, input logic stop);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        drive_bit(mpb);
        drive_bit(stop);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic cfg(input logic en, input logic hunt);
        cfg_rx_en = en; cfg_hunt = hunt; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear(input logic f, input logic o, input logic e);
        clr_full = f; clr_ovr = o; clr_frm = e; clr_we = 1'b1;
        @(negedge clk);
        clr_we = 1'b0; clr_full = 1'b0; clr_ovr = 1'b0; clr_frm = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rx_en", rx_en_o, 0);
        check("R1 hunt", hunt_o, 0);
        check("R1 flags", {full_o, ovr_o, frm_o}, 0);
        check("R1 data", data_o, 0);

        cfg(1'b1, 1'b1);
        check("R12 cfg write", {rx_en_o, hunt_o}, 2'b11);
        repeat (BIT_CLK) @(negedge clk);

        // Table: R3 drops in hunt, R4 address exit, R5 accept after hunt, R2 format
        for (int k = 0; k < 5; k++) begin
            send(VECS[k].d, VECS[k].mpb, VECS[k].stop);
            check("R2/R3/R4/R5 full", full_o, VECS[k].e_full);
            check("R2/R3/R4/R5 data", data_o, VECS[k].e_data);
            check("R3/R4 hunt", hunt_o, VECS[k].e_hunt);
            check("R3 frm", frm_o, VECS[k].e_frm);
            if (full_o) begin
                clear(1'b1, 1'b0, 1'b0);
                check("R12 clear full", full_o, 0);
            end
        end

        // R6 overrun
        send(8'h01, 1'b0, 1'b1);
        check("R2 load", data_o, 8'h01);
        send(8'h02, 1'b0, 1'b1);
        check("R6 ovr set", ovr_o, 1);
        check("R6 data kept", data_o, 8'h01);
        // R7 frozen
        clear(1'b1, 1'b0, 1'b0);
        send(8'h03, 1'b0, 1'b1);
        check("R7 frozen full", full_o, 0);
        check("R7 frozen data", data_o, 8'h01);
        clear(1'b0, 1'b1, 1'b0);
        send(8'h04, 1'b0, 1'b1);
        check("R7 resume", data_o, 8'h04);
        clear(1'b1, 1'b0, 1'b0);

        // R8 framing error, then R9 break visible
        send(8'h77, 1'b0, 1'b0);
        check("R8 frm set", frm_o, 1);
        check("R8 data kept", data_o, 8'h04);
        check("R8 full kept", full_o, 0);
        rxd_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 line low", line_o, 0);
        rxd_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 line high", line_o, 1);
        clear(1'b0, 1'b0, 1'b1);
        send(8'h5A, 1'b0, 1'b1);
        check("R7 resume after frm", data_o, 8'h5A);
        clear(1'b1, 1'b0, 1'b0);

        // R10 abandon on disable
        drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b0);
        cfg(1'b0, 1'b0);
        check("R10 disabled", rx_en_o, 0);
        for (int i = 0; i < 7; i++) drive_bit(1'b1);
        drive_bit(1'b1);
        check("R10 no load", {full_o, frm_o, ovr_o}, 0);
        cfg(1'b1, 1'b0);
        send(8'hC3, 1'b0, 1'b1);
        check("R10 recover", data_o, 8'hC3);
        clear(1'b1, 1'b0, 1'b0);

        // R11 short glitch
        rxd_i = 1'b0;
        repeat (4) @(negedge clk);
        rxd_i = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        check("R11 glitch ignored", {full_o, frm_o}, 0);
        send(8'h96, 1'b0, 1'b1);
        check("R11 next frame", data_o, 8'h96);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule